// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block is a first-in first-out buffer whose write port and read port run on two unrelated clocks. Words of 9 bits are written on rising write-clock edges while the active-low write enable is asserted, and they leave in the same order on rising read-clock edges while the active-low read enable is asserted. Four active-low status outputs report the buffer level: empty and almost-empty belong to the read clock, and full and almost-full belong to the write clock. Each side sees the other side's pointer through a Gray-coded two-flop synchronizer. A flag can therefore stay asserted for a few extra cycles after the far side has moved. It never releases early.

The almost-empty and almost-full thresholds are held in two offset registers, each reset to 7. Pulling the load strobe low turns the data ports into a path to those registers. A write cycle with the strobe low stores the low bits of the data input into the next offset register. A read cycle with the strobe low returns the next offset register on the data output. Both ports step through the registers in a fixed order, almost-empty first and almost-full second. Offsets are meant to be programmed while the FIFO is idle; a new value reaches the flags after a few cycles. The data output keeps the last word read until another read or offset read replaces it.

Top module: `dcfifo_pflags`

## Requirements
- R1: While rst_n is low, dout is 0, empty_n and aempty_n are 0, full_n and afull_n are 1, and any write or read enable held during reset stores or removes nothing.
- R2: Words leave the read port in exactly the order in which they were accepted at the write port. A word is accepted on a write-clock edge where wen_n=0, ld_n=1 and full_n=1. A word is removed on a read-clock edge where ren_n=0, ld_n=1 and empty_n=1, and it appears on dout after that edge.
- R3: A write enable seen while full_n is 0 stores nothing and does not overwrite any held word. A FIFO that is written DEPTH+3 times without reads accepts exactly DEPTH words.
- R4: A read enable seen while empty_n is 0 leaves dout unchanged.
- R5: Once both clocks have run idle for 8 cycles, empty_n is 0 exactly when the stored word count is 0.
- R6: Once both clocks have run idle for 8 cycles, full_n is 0 exactly when the stored word count equals DEPTH.
- R7: Once both clocks have run idle for 8 cycles, aempty_n is 0 exactly when the word count is less than or equal to the almost-empty offset.
- R8: Once both clocks have run idle for 8 cycles, afull_n is 0 exactly when DEPTH minus the word count is less than or equal to the almost-full offset.
- R9: After reset both offsets are 7.
- R10: A write cycle with ld_n=0 stores din[AW-1:0] (AW = log2 DEPTH) into an offset register. The target alternates, starting at the almost-empty offset after reset, then the almost-full offset, then back to almost-empty. Such a write adds no word to the FIFO.
- R11: A read cycle with ld_n=0 places the selected offset on dout, zero-extended to 9 bits. The selection alternates starting at the almost-empty offset after reset. Such a read removes no word from the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous reset, active low, shared by both domains |
| wen_n | input | 1 | Write enable, active low |
| din | input | 9 | Write data, or offset value when ld_n is low |
| ren_n | input | 1 | Read enable, active low |
| ld_n | input | 1 | Offset register access strobe, active low |
| dout | output | 9 | Last word read, or offset read-back |
| empty_n | output | 1 | Low when no word is stored (read clock) |
| aempty_n | output | 1 | Low when occupancy is at or below the almost-empty offset (read clock) |
| full_n | output | 1 | Low when DEPTH words are stored (write clock) |
| afull_n | output | 1 | Low when free space is at or below the almost-full offset (write clock) |

## Verification
The bench writes DEPTH+3 words with no reads and then drains the FIFO. A design that lets a write through while full would accept too many words or overwrite the oldest word, and the drained sequence would not match. Reads issued while the FIFO is empty must leave dout alone; a design that reads anyway would show a stale memory word. The flag thresholds are checked one word on each side of both offsets, first with the default of 7 and then with reprogrammed values. An off-by-one compare, or an offset load that goes to the wrong register, shows up as a flag that is wrong at one of those levels. Offset loads are also done with words already stored, so a design that pushes or pops during offset access loses or gains a word in the following data check.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

  typedef enum logic {OFS_AE = 1'b0, OFS_AF = 1'b1} ofs_sel_e;

  // binary to reflected Gray code
  function automatic logic [31:0] gray_of(logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  // Gray code back to binary; bits above the real width are zero
  function automatic logic [31:0] bin_of(logic [31:0] g);
    logic [31:0] b;
    b = g;
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // distance a-b modulo 2**pw (pointer difference)
  function automatic logic [31:0] span(logic [31:0] a, logic [31:0] b, int unsigned pw);
    return (a - b) & ((32'd1 << pw) - 32'd1);
  endfunction

endpackage

// File: rtl/dcf_sync2.sv
module dcf_sync2 #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/dcf_wr_ctrl.sv
module dcf_wr_ctrl
  import dcf_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int DEF_OFS = 7,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  logic          wen_n,
  input  logic          ld_n,
  input  logic [AW-1:0] ld_val,
  input  logic [AW:0]   rgray_s,
  output logic          wr_fire,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wgray,
  output logic          full_n,
  output logic          afull_n,
  output logic [AW-1:0] ofs_ae,
  output logic [AW-1:0] ofs_af
);
  localparam int PW = AW + 1;

  logic [AW:0] wbin, wbin_nx, rbin_s, fill_now, fill_nx, free_nx;
  logic        ld_fire;
  ofs_sel_e    sel;

  assign ld_fire  = !wen_n && !ld_n;
  assign wr_fire  = !wen_n && ld_n && full_n;
  assign wbin_nx  = wbin + PW'(wr_fire);
  assign rbin_s   = PW'(bin_of(32'(rgray_s)));
  assign fill_now = PW'(span(32'(wbin), 32'(rbin_s), PW));
  assign fill_nx  = PW'(span(32'(wbin_nx), 32'(rbin_s), PW));
  assign free_nx  = PW'(DEPTH) - fill_nx;
  assign waddr    = wbin[AW-1:0];

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin    <= '0;
      wgray   <= '0;
      full_n  <= 1'b1;
      afull_n <= 1'b1;
    end else begin
      wbin    <= wbin_nx;
      wgray   <= PW'(gray_of(32'(wbin_nx)));
      full_n  <= (free_nx != '0);
      afull_n <= (free_nx > {1'b0, ofs_af});
    end
  end

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_ae <= AW'(DEF_OFS);
      ofs_af <= AW'(DEF_OFS);
      sel    <= OFS_AE;
    end else if (ld_fire) begin
      if (sel == OFS_AE) ofs_ae <= ld_val;
      else               ofs_af <= ld_val;
      sel <= (sel == OFS_AE) ? OFS_AF : OFS_AE;
    end
  end

  // R3
  no_overflow_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    fill_now <= PW'(DEPTH));

  // R3
  blocked_write_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    (!wen_n && ld_n && !full_n) |=> $stable(wbin));

  // R2
  gray_step_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    $countones(wgray ^ $past(wgray)) <= 1);

  // R10
  ofs_ae_load_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    (ld_fire && sel == OFS_AE) |=> (ofs_ae == $past(ld_val)) && $stable(ofs_af) && $stable(wbin));
endmodule

// File: rtl/dcf_rd_ctrl.sv
module dcf_rd_ctrl
  import dcf_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DW    = 9,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          ren_n,
  input  logic          ld_n,
  input  logic [AW:0]   wgray_s,
  input  logic [DW-1:0] mem_q,
  input  logic [AW-1:0] ofs_ae,
  input  logic [AW-1:0] ofs_af,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic [DW-1:0] dout,
  output logic          empty_n,
  output logic          aempty_n
);
  localparam int PW = AW + 1;

  logic [AW:0] rbin, rbin_nx, wbin_s, occ_now, occ_nx;
  logic        rd_fire, ld_rd;
  ofs_sel_e    sel;

  assign rd_fire = !ren_n && ld_n && empty_n;
  assign ld_rd   = !ren_n && !ld_n;
  assign rbin_nx = rbin + PW'(rd_fire);
  assign wbin_s  = PW'(bin_of(32'(wgray_s)));
  assign occ_now = PW'(span(32'(wbin_s), 32'(rbin), PW));
  assign occ_nx  = PW'(span(32'(wbin_s), 32'(rbin_nx), PW));
  assign raddr   = rbin[AW-1:0];

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin     <= '0;
      rgray    <= '0;
      empty_n  <= 1'b0;
      aempty_n <= 1'b0;
    end else begin
      rbin     <= rbin_nx;
      rgray    <= PW'(gray_of(32'(rbin_nx)));
      empty_n  <= (occ_nx != '0);
      aempty_n <= (occ_nx > {1'b0, ofs_ae});
    end
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0;
      sel  <= OFS_AE;
    end else if (rd_fire) begin
      dout <= mem_q;
    end else if (ld_rd) begin
      dout <= (sel == OFS_AE) ? DW'(ofs_ae) : DW'(ofs_af);
      sel  <= (sel == OFS_AE) ? OFS_AF : OFS_AE;
    end
  end

  // R4
  no_underflow_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    occ_now <= PW'(DEPTH));

  // R4
  hold_dout_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    (!ren_n && ld_n && !empty_n) |=> $stable(dout));

  // R11
  ld_no_pop_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    (!ld_n) |=> $stable(rbin));

  // R2
  rgray_step_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    $countones(rgray ^ $past(rgray)) <= 1);
endmodule

// File: rtl/dcfifo_pflags.sv
module dcfifo_pflags #(
  parameter int DEPTH   = 64,
  parameter int DW      = 9,
  parameter int DEF_OFS = 7
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          wen_n,
  input  logic [DW-1:0] din,
  input  logic          ren_n,
  input  logic          ld_n,
  output logic [DW-1:0] dout,
  output logic          empty_n,
  output logic          aempty_n,
  output logic          full_n,
  output logic          afull_n
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] mem_q;
  logic [AW-1:0] waddr, raddr, ofs_ae, ofs_af;
  logic [AW:0]   wgray, rgray, wgray_s, rgray_s;
  logic          wr_fire;

  dcf_wr_ctrl #(.DEPTH(DEPTH), .DEF_OFS(DEF_OFS)) u_wr (
    .wclk(wclk), .rst_n(rst_n), .wen_n(wen_n), .ld_n(ld_n),
    .ld_val(din[AW-1:0]), .rgray_s(rgray_s), .wr_fire(wr_fire),
    .waddr(waddr), .wgray(wgray), .full_n(full_n), .afull_n(afull_n),
    .ofs_ae(ofs_ae), .ofs_af(ofs_af)
  );

  dcf_sync2 #(.W(AW + 1)) u_w2r (.clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_s));
  dcf_sync2 #(.W(AW + 1)) u_r2w (.clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_s));

  dcf_rd_ctrl #(.DEPTH(DEPTH), .DW(DW)) u_rd (
    .rclk(rclk), .rst_n(rst_n), .ren_n(ren_n), .ld_n(ld_n),
    .wgray_s(wgray_s), .mem_q(mem_q), .ofs_ae(ofs_ae), .ofs_af(ofs_af),
    .raddr(raddr), .rgray(rgray), .dout(dout),
    .empty_n(empty_n), .aempty_n(aempty_n)
  );

  always_ff @(posedge wclk) begin
    if (wr_fire) mem[waddr] <= din;
  end

  assign mem_q = mem[raddr];
endmodule

// File: tb/dcfifo_pflags_bench.sv
`timescale 1ns/1ps
module dcfifo_pflags_bench;
  localparam int DEPTH = 64;
  localparam int DW    = 9;
  localparam int AW    = $clog2(DEPTH);

  logic wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic wen_n = 1'b1, ren_n = 1'b1, ld_n = 1'b1;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic empty_n, aempty_n, full_n, afull_n;

  int errs = 0, chks = 0;
  bit done = 1'b0;
  logic [DW-1:0] q[$];
  int ae_o = 7, af_o = 7;

  always #2.5 wclk = ~wclk;
  always #3.5 rclk = ~rclk;

  dcfifo_pflags #(.DEPTH(DEPTH), .DW(DW), .DEF_OFS(7)) u_dcfifo_pflags (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wen_n(wen_n), .din(din),
    .ren_n(ren_n), .ld_n(ld_n), .dout(dout), .empty_n(empty_n),
    .aempty_n(aempty_n), .full_n(full_n), .afull_n(afull_n)
  );

  function automatic bit exp_empty_n(int c); return c != 0; endfunction
  function automatic bit exp_full_n(int c); return c != DEPTH; endfunction
  function automatic bit exp_aempty_n(int c, int o); return !(c <= o); endfunction
  function automatic bit exp_afull_n(int c, int o); return !((DEPTH - c) <= o); endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    chks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr1(logic [DW-1:0] v);
    bit fire;
    @(negedge wclk);
    wen_n = 1'b0; din = v; fire = full_n;
    @(negedge wclk);
    wen_n = 1'b1;
    if (fire) q.push_back(v);
  endtask

  task automatic rd1();
    bit fire;
    logic [DW-1:0] prev, exp;
    @(negedge rclk);
    ren_n = 1'b0; fire = empty_n; prev = dout;
    @(negedge rclk);
    ren_n = 1'b1;
    if (fire) begin
      exp = q.pop_front();
      chk(dout == exp, "R2 order", int'(dout), int'(exp));
    end else begin
      chk(dout == prev, "R4 hold on empty", int'(dout), int'(prev));
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge rclk);
    repeat (8) @(negedge wclk);
  endtask

  task automatic chk_flags(string tag);
    int c;
    settle();
    c = q.size();
    chk(empty_n  == exp_empty_n(c),        {"R5 ", tag}, int'(empty_n),  int'(exp_empty_n(c)));
    chk(full_n   == exp_full_n(c),         {"R6 ", tag}, int'(full_n),   int'(exp_full_n(c)));
    chk(aempty_n == exp_aempty_n(c, ae_o), {"R7 ", tag}, int'(aempty_n), int'(exp_aempty_n(c, ae_o)));
    chk(afull_n  == exp_afull_n(c, af_o),  {"R8 ", tag}, int'(afull_n),  int'(exp_afull_n(c, af_o)));
  endtask

  task automatic fill_to(int n);
    int guard = 0;
    while (q.size() < n && guard < 4 * DEPTH) begin
      wr1(DW'($urandom));
      guard++;
    end
  endtask

  task automatic drain_to(int n);
    int guard = 0;
    while (q.size() > n && guard < 8 * DEPTH) begin
      rd1();
      guard++;
    end
  endtask

  task automatic ld_wr(logic [DW-1:0] v);
    @(negedge wclk);
    ld_n = 1'b0; wen_n = 1'b0; din = v;
    @(negedge wclk);
    wen_n = 1'b1; ld_n = 1'b1;
  endtask

  task automatic ld_rd(logic [DW-1:0] exp, string req);
    @(negedge rclk);
    ld_n = 1'b0; ren_n = 1'b0;
    @(negedge rclk);
    ren_n = 1'b1; ld_n = 1'b1;
    chk(dout == exp, req, int'(dout), int'(exp));
  endtask

  initial begin
    void'($urandom(32'd1234));
    // R1: reset state, with enables driven during reset
    #1;
    wen_n = 1'b0; ren_n = 1'b0; din = 9'h155;
    repeat (4) @(negedge wclk);
    chk(dout == '0,        "R1 dout",     int'(dout),     0);
    chk(empty_n == 1'b0,   "R1 empty_n",  int'(empty_n),  0);
    chk(aempty_n == 1'b0,  "R1 aempty_n", int'(aempty_n), 0);
    chk(full_n == 1'b1,    "R1 full_n",   int'(full_n),   1);
    chk(afull_n == 1'b1,   "R1 afull_n",  int'(afull_n),  1);
    wen_n = 1'b1; ren_n = 1'b1;
    #1.3 rst_n = 1'b1;
    chk_flags("R1 nothing stored by reset");

    // R9: default offsets 7 at both ends
    fill_to(7);  chk_flags("R9 occ 7");
    fill_to(8);  chk_flags("R9 occ 8");
    fill_to(56); chk_flags("R9 occ 56");
    fill_to(57); chk_flags("R9 occ 57");

    // R3: overflow attempt
    repeat (DEPTH - 57 + 3) wr1(DW'($urandom));
    chk(q.size() == DEPTH, "R3 accepted count", q.size(), DEPTH);
    chk_flags("R3 full");
    drain_to(0);
    chk_flags("R5 drained");

    // R4: reads on empty
    repeat (3) rd1();

    // R10 / R11: offset access with two words stored
    fill_to(2);
    settle();
    ld_wr(9'h1C3);               // almost-empty offset <- 3
    ld_wr(9'h005);               // almost-full offset  <- 5
    ld_wr(9'h104);               // wraps: almost-empty <- 4
    ae_o = 4; af_o = 5;
    chk_flags("R10 no push on load");
    ld_rd(9'd4, "R11 readback almost-empty");
    ld_rd(9'd5, "R11 readback almost-full");
    ld_rd(9'd4, "R11 readback wraps");
    chk_flags("R11 no pop on load");
    fill_to(4);  chk_flags("R10 occ 4");
    fill_to(5);  chk_flags("R10 occ 5");
    fill_to(58); chk_flags("R10 occ 58");
    fill_to(59); chk_flags("R10 occ 59");
    drain_to(0);

    // random mixed traffic (R2, R3, R4)
    fork
      begin
        repeat (500) begin
          if ($urandom % 3 != 0) wr1(DW'($urandom));
          else @(negedge wclk);
        end
      end
      begin
        repeat (500) begin
          if ($urandom % 2 != 0) rd1();
          else @(negedge rclk);
        end
      end
    join
    chk_flags("random end");
    drain_to(0);
    chk_flags("random drained");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end

  initial begin
    #900000;
    if (!done) begin
      errs++;
      chks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, chks);
      $finish;
    end
  end
endmodule